// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block fetches bursts of 16-bit words from an external NOR flash or PSRAM that runs in synchronous burst mode. It divides the system clock down to a memory clock, selects the device and drives a 26-bit word address with an active-low address-valid strobe. It then counts a programmable number of memory clock rising edges before the first word can arrive. After that it takes one word on each rising edge at which the device does not stall it through an active-low wait line.

A client offers a start address, a burst length and three timing fields with `req_valid` while `req_ready` is high. The engine latches all of them on that edge and returns the words in order on `rd_data` with a one-cycle `rd_valid` strobe, marking the final word with `rd_last`. Once the final word is in, the device is released and a bus turnaround interval must pass before the next request is taken.

Top module: `sburst_rd`

## Requirements
- R1: The memory clock period is R system cycles, where R = `cfg_div`+1 for `cfg_div` 1..15 and R = 2 for `cfg_div` 0. In each period `mem_clk` is high for ceil(R/2) cycles and low for floor(R/2) cycles. Every change of `mem_clk` happens at a system clock edge, and `mem_clk` is low whenever no burst is in progress.
- R2: A request is accepted at the edge where `req_valid` and `req_ready` are both high. From that edge on, `mem_ce_n` and `mem_adv_n` are low and `mem_addr` carries the requested address. The first rising edge of `mem_clk` (rising edge 0) comes floor(R/2) system cycles after acceptance.
- R3: `mem_adv_n` stays low for exactly R system cycles after acceptance, so it spans rising edge 0 and no other. `mem_oe_n` falls at the edge where `mem_adv_n` rises and stays low until the burst ends.
- R4: With latency L = `cfg_lat`+2 (2..17), no word is taken at rising edges 0 to L-1, whatever `mem_wait_n` and `mem_dq` hold.
- R5: From rising edge L on, a word is taken from `mem_dq` at each rising edge where `mem_wait_n`, sampled at that edge, is high. An edge where `mem_wait_n` is low takes nothing, and the memory clock keeps running.
- R6: Each word taken appears on `rd_data` with `rd_valid` high for the one system cycle that follows its capture edge. Words come out in capture order, `req_len`+1 of them per burst, and `rd_last` is high together with the final one.
- R7: At the edge that takes the final word, `mem_ce_n` and `mem_oe_n` go high and `mem_clk` parks low, with no further rising edge.
- R8: `req_ready` goes high exactly T = `cfg_turn`+1 system cycles after the final capture edge. A `req_valid` held high at any earlier point of the burst or turnaround is not accepted.
- R9: The address, length and timing fields are latched at acceptance. Changing those inputs during a burst changes neither its timing nor its data.
- R10: After reset `req_ready`, `mem_ce_n`, `mem_oe_n` and `mem_adv_n` are high, and `mem_clk` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_addr | input | 26 | Start word address |
| req_len | input | 8 | Burst length minus one |
| cfg_div | input | 4 | Memory clock ratio minus one (0 acts as 1) |
| cfg_lat | input | 4 | First-data latency minus two, in memory clocks |
| cfg_turn | input | 4 | Turnaround minus one, in system cycles |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | 16 | Returned word |
| rd_last | output | 1 | Returned word is the final one of the burst |
| mem_clk | output | 1 | Divided memory clock |
| mem_addr | output | 26 | Word address to the memory |
| mem_ce_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_wait_n | input | 1 | Stall from the memory, active low |
| mem_dq | input | 16 | Data from the memory |

## Verification
A latency count that is off by one makes the engine take either a word the device never meant to drive or the next word in the sequence. That shows up on `rd_data` at the first `rd_valid`, well before the burst ends. A divider phase error moves `mem_clk` away from its expected level within one memory period, and a wrong turnaround count moves `req_ready` by a cycle at the end of the first burst. A stall that is ignored shifts every later word, and because the bench holds a decoy request during the burst, a premature return to idle starts a spurious burst that shows up at once on the device select.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    localparam int CFG_W   = 4;
    localparam int RATIO_W = CFG_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_TURN  = 2'd2
    } seq_state_e;

    // Timing of one burst, already decoded to cycle counts
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;  // system cycles per memory clock
        logic [RATIO_W-1:0] lat;    // memory clocks before first word
        logic [RATIO_W-1:0] turn;   // system cycles of turnaround
    } timing_t;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CFG_W-1:0] f);
        return (f == '0) ? RATIO_W'(2) : RATIO_W'(f) + RATIO_W'(1);
    endfunction

    function automatic logic [RATIO_W-1:0] lat_of(input logic [CFG_W-1:0] f);
        return RATIO_W'(f) + RATIO_W'(2);
    endfunction

    function automatic logic [RATIO_W-1:0] turn_of(input logic [CFG_W-1:0] f);
        return RATIO_W'(f) + RATIO_W'(1);
    endfunction

endpackage

// File: rtl/sburst_clkgen.sv
module sburst_clkgen
    import sburst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,    // burst accepted on this edge
    input  logic               active,  // burst in progress
    input  logic               stop,    // park the clock at this edge
    input  logic [RATIO_W-1:0] ratio,
    output logic               mclk,
    output logic               tick,    // next edge is a memory clock rise
    output logic               mid      // next edge ends the first period
);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] cnt_nxt;
    logic [RATIO_W-1:0] hi_len;
    logic [RATIO_W-1:0] last_ph;

    assign hi_len  = ratio - (ratio >> 1);
    assign last_ph = ratio - RATIO_W'(1);
    assign cnt_nxt = (cnt == last_ph) ? '0 : cnt + RATIO_W'(1);
    assign tick    = active && (cnt == last_ph);
    assign mid     = active && (cnt == hi_len - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            mclk <= 1'b0;
        end else if (load) begin
            cnt  <= hi_len;     // start in the low phase
            mclk <= 1'b0;
        end else if (active && !stop) begin
            cnt  <= cnt_nxt;
            mclk <= (cnt_nxt < hi_len);
        end else begin
            mclk <= 1'b0;
        end
    end

    a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < ratio));

    a_r1_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        (active && !stop && !load && !tick) |=> !$rose(mclk));

endmodule

// File: rtl/sburst_seq.sv
module sburst_seq
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  timing_t           tim_new,
    input  logic              tick,
    input  logic              mid,
    input  logic              mem_wait_n,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              req_ready,
    output logic              accept,
    output logic              active,
    output logic              stop,
    output timing_t           tim,
    output logic [ADDR_W-1:0] addr_q,
    output logic              ce_n,
    output logic              oe_n,
    output logic              adv_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last
);

    seq_state_e         state;
    logic [LEN_W-1:0]   left;
    logic [RATIO_W-1:0] lat_cnt;
    logic [RATIO_W-1:0] tcnt;
    logic               take;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign active    = (state == ST_BURST);
    assign take      = active && tick && (lat_cnt == '0) && mem_wait_n;
    assign stop      = take && (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            left     <= '0;
            lat_cnt  <= '0;
            tcnt     <= '0;
            tim      <= '0;
            addr_q   <= '0;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            adv_n    <= 1'b1;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
        end else begin
            rd_valid <= take;
            rd_last  <= stop;
            if (take) rd_data <= mem_dq;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_BURST;
                        tim     <= tim_new;
                        addr_q  <= req_addr;
                        left    <= req_len;
                        lat_cnt <= tim_new.lat;
                        ce_n    <= 1'b0;
                        adv_n   <= 1'b0;
                    end
                end
                ST_BURST: begin
                    if (mid && !adv_n) begin
                        adv_n <= 1'b1;
                        oe_n  <= 1'b0;
                    end
                    if (tick && lat_cnt != '0) lat_cnt <= lat_cnt - RATIO_W'(1);
                    if (take) begin
                        left <= left - LEN_W'(1);
                        if (left == '0) begin
                            state <= ST_TURN;
                            tcnt  <= tim.turn - RATIO_W'(1);
                            ce_n  <= 1'b1;
                            oe_n  <= 1'b1;
                        end
                    end
                end
                ST_TURN: begin
                    if (tcnt == '0) state <= ST_IDLE;
                    else            tcnt  <= tcnt - RATIO_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r4_latency_gate: assert property (@(posedge clk) disable iff (rst)
        (tick && lat_cnt != '0) |=> !rd_valid);

    a_r3_adv_inside_select: assert property (@(posedge clk) disable iff (rst)
        !adv_n |-> !ce_n);

    a_r8_turn_after_last: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> (!req_ready && ce_n && rd_valid));

    a_r10_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ce_n && oe_n && adv_n));

endmodule

// File: rtl/sburst_rd.sv
module sburst_rd
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CFG_W-1:0]  cfg_div,
    input  logic [CFG_W-1:0]  cfg_lat,
    input  logic [CFG_W-1:0]  cfg_turn,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              mem_clk,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_adv_n,
    input  logic              mem_wait_n,
    input  logic [DATA_W-1:0] mem_dq
);

    timing_t            tim_new;
    timing_t            tim;
    logic               accept;
    logic               active;
    logic               stop;
    logic               tick;
    logic               mid;
    logic [RATIO_W-1:0] ratio_use;

    assign tim_new.ratio = ratio_of(cfg_div);
    assign tim_new.lat   = lat_of(cfg_lat);
    assign tim_new.turn  = turn_of(cfg_turn);
    assign ratio_use     = accept ? tim_new.ratio : tim.ratio;

    sburst_clkgen u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .active (active),
        .stop   (stop),
        .ratio  (ratio_use),
        .mclk   (mem_clk),
        .tick   (tick),
        .mid    (mid)
    );

    sburst_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .tim_new    (tim_new),
        .tick       (tick),
        .mid        (mid),
        .mem_wait_n (mem_wait_n),
        .mem_dq     (mem_dq),
        .req_ready  (req_ready),
        .accept     (accept),
        .active     (active),
        .stop       (stop),
        .tim        (tim),
        .addr_q     (mem_addr),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .adv_n      (mem_adv_n),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last)
    );

    a_r7_clock_only_selected: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_clk) |-> !mem_ce_n);

    a_r6_data_while_busy: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !req_ready);

endmodule

// File: tb/tb_sburst_rd.sv
`timescale 1ns/1ps
module tb_sburst_rd;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [3:0]  cfg_div = '0;
    logic [3:0]  cfg_lat = '0;
    logic [3:0]  cfg_turn = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_last;
    logic        mem_clk;
    logic [25:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_oe_n;
    logic        mem_adv_n;
    logic        mem_wait_n = 1'b1;
    logic [15:0] mem_dq = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int seed_dummy;

    always #2 clk = ~clk;

    sburst_rd dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_div(cfg_div),
        .cfg_lat(cfg_lat), .cfg_turn(cfg_turn), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last), .mem_clk(mem_clk),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_adv_n(mem_adv_n), .mem_wait_n(mem_wait_n), .mem_dq(mem_dq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pat(input logic [25:0] a, input int idx);
        return a[15:0] ^ 16'(idx * 16'h01F3) ^ 16'h5A00 ^ {6'd0, a[25:16]};
    endfunction

    task automatic run_burst(input logic [25:0] a, input logic [7:0] ln,
                             input logic [3:0] fd, input logic [3:0] fl,
                             input logic [3:0] ft, input int wait_pct);
        int r, lo, hi, lat, trn, c, ck, widx, n;
        bit capn, running, is_rise, w;
        r   = (fd == 0) ? 2 : int'(fd) + 1;
        lo  = r / 2;
        hi  = r - lo;
        lat = int'(fl) + 2;
        trn = int'(ft) + 1;
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = a;
        req_len    = ln;
        cfg_div    = fd;
        cfg_lat    = fl;
        cfg_turn   = ft;
        mem_wait_n = 1'($urandom);
        mem_dq     = 16'($urandom);
        @(negedge clk);
        // decoy request held during the burst (R8) and new fields (R9)
        req_addr = ~a;
        req_len  = 8'($urandom);
        c = 0; ck = -1; widx = 0; capn = 0;
        forever begin
            if (capn) begin
                chk("R6 rd_valid", 32'(rd_valid), 32'd1);
                chk("R5 rd_data", 32'(rd_data), 32'(pat(a, widx)));
                chk("R6 rd_last", 32'(rd_last), 32'(widx == int'(ln)));
                widx++;
                if (widx == int'(ln) + 1) ck = c;
            end else begin
                chk("R4 rd_valid idle", 32'(rd_valid), 32'd0);
            end
            running = (ck < 0);
            chk("R1 mem_clk", 32'(mem_clk), 32'(running && (((hi + c) % r) < hi)));
            chk("R3 mem_adv_n", 32'(mem_adv_n), 32'(c >= r));
            chk("R3 mem_oe_n", 32'(mem_oe_n), 32'(c < r || ck >= 0));
            chk("R7 mem_ce_n", 32'(mem_ce_n), 32'(ck >= 0));
            chk("R8 req_ready", 32'(req_ready), 32'(ck >= 0 && c >= ck + trn));
            if (c < r) chk("R2 mem_addr", 32'(mem_addr), 32'(a));
            if (ck >= 0 && c == ck + trn) break;
            cfg_div  = 4'($urandom);
            cfg_lat  = 4'($urandom);
            cfg_turn = 4'($urandom);
            is_rise = running && (c + 1 >= lo) && (((c + 1 - lo) % r) == 0);
            n = (c + 1 - lo) / r;
            if (is_rise && n >= lat) begin
                w = ($urandom % 100) >= wait_pct;
                mem_wait_n = w;
                mem_dq = w ? pat(a, widx) : 16'($urandom);
                capn = w;
            end else begin
                mem_wait_n = 1'($urandom);
                mem_dq     = 16'($urandom);
                capn       = 0;
            end
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 req_ready", 32'(req_ready), 32'd1);
        chk("R10 mem_ce_n", 32'(mem_ce_n), 32'd1);
        chk("R10 mem_oe_n", 32'(mem_oe_n), 32'd1);
        chk("R10 mem_adv_n", 32'(mem_adv_n), 32'd1);
        chk("R10 mem_clk", 32'(mem_clk), 32'd0);
        chk("R10 rd_valid", 32'(rd_valid), 32'd0);
        // directed corners
        run_burst(26'h3FFFFFF, 8'd0, 4'd0, 4'd0, 4'd0, 0);    // R1 ratio 2 via 0, min latency
        run_burst(26'h0000123, 8'd3, 4'd1, 4'd0, 4'd0, 40);   // R1 ratio 2 via 1
        run_burst(26'h1234567, 8'd3, 4'd15, 4'd15, 4'd15, 30); // max ratio, latency, turnaround
        run_burst(26'h00ABCDE, 8'd5, 4'd2, 4'd3, 4'd2, 50);   // odd ratio 3
        run_burst(26'h2000000, 8'd255, 4'd1, 4'd1, 4'd0, 20); // longest burst
        for (int i = 0; i < 30; i++) begin
            run_burst(26'($urandom), 8'($urandom % 16), 4'($urandom),
                      4'($urandom), 4'($urandom), int'($urandom % 50));
        end
        @(negedge clk);
        chk("R10 idle after bursts", 32'(mem_ce_n), 32'd1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule